// File: doc/BRIEF.md
# Port-Mapped External RAM Reader

This block gives a host with an 8-bit I/O-mapped peripheral bus read access to a detachable byte-wide static RAM. The host cannot address the RAM directly. It first writes the low byte of the RAM address to one port and the upper bits to a second port. It then reads the stored byte through a third port. All three ports sit inside a 32-byte window at I/O base 0x300.

The window decode is combinational. It requires a processor cycle, meaning the DMA address-enable line is low, and an active read or write strobe. The resulting select drives the RAM chip select and the enable of the host-side data transceiver. The transceiver direction follows the host read strobe.

The two address registers are clocked. Each commits on the deasserting edge of the host write strobe, which is seen as a falling edge of the sampled strobe. A parameter sets the usable RAM size, either 2 KB or 8 KB. Address bits above that size are forced to zero at the RAM.

Top module: `pmio_ram_reader`

## Requirements
- R1: `card_sel_o` is high, and `ram_cs_no` low, exactly when `io_addr_i[9:5]` equals 5'b11000 (window 0x300–0x31F), `aen_i` is low and at least one of `io_rd_ni`/`io_wr_ni` is low.
- R2: While `aen_i` is high the card is not selected, and a write has no effect on either address register.
- R3: Sub-port selection uses `io_addr_i[4:2]`: 0 is the low-address port, 1 is the high-address port and 2 is the data port. `io_addr_i[1:0]` is ignored, so 0x300–0x303, 0x304–0x307 and 0x308–0x30B alias.
- R4: A write to the low-address port loads `io_data_i[7:0]` into RAM address bits 7..0. The new value appears on `ram_addr_o` no later than the second rising clock edge after `io_wr_ni` returns high.
- R5: A write to the high-address port loads `io_data_i[4:0]` as RAM address bits 12..8, with the same timing as R4.
- R6: With `RAM_ADDR_W` = 11 (2 KB, the default), `ram_addr_o[12:11]` is always zero, even when the high register holds a larger value. With 13, all bits pass.
- R7: A read of the data port drives `ram_oe_no` low and returns `ram_data_i` on `io_data_o`. `ram_oe_no` is high at all other times.
- R8: A read of the low-address port returns the low register. A read of the high-address port returns {3'b000, high register}.
- R9: A read of sub-ports 3..7 inside the window returns 8'hFF. A write to the data port or to sub-ports 3..7 changes neither address register.
- R10: `xcvr_dir_o` is high (toward the host) exactly while `io_rd_ni` is low. `io_data_oe_o` is high only on a selected read.
- R11: After reset both address registers are zero, so `ram_addr_o` is zero.
- R12: While `io_wr_ni` stays low, `ram_addr_o` does not change. A register commits only after the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used to sample the write strobe |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 10 | Host I/O address |
| io_data_i | input | 8 | Host write data |
| io_rd_ni | input | 1 | Host I/O read strobe, active low |
| io_wr_ni | input | 1 | Host I/O write strobe, active low |
| aen_i | input | 1 | DMA address enable; high marks a DMA cycle |
| io_data_o | output | 8 | Read data toward the host |
| io_data_oe_o | output | 1 | Read data valid, drive host bus |
| xcvr_dir_o | output | 1 | Transceiver direction, 1 = toward host |
| card_sel_o | output | 1 | Window select, transceiver enable |
| ram_addr_o | output | 13 | RAM address, masked to configured size |
| ram_cs_no | output | 1 | RAM chip select, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_data_i | input | 8 | RAM read data |

## Verification
The hardest case to reach from the ports is a write strobe held low for several cycles. In that case the register must stay put until the release, and then commit the captured byte two edges later. The stimulus holds `io_wr_ni` low for five cycles. A per-clock comparison against the unchanged model address checks every one of those cycles. After the release, the comparison pauses for the commit window and then checks the new address. Masked high bits, aliased sub-port addresses, DMA-qualified writes and writes to the reserved and data ports are driven the same way. Each of these is checked by reading back through the address ports.

// File: rtl/pmio_ram_reader_pkg.sv
package pmio_ram_reader_pkg;
  localparam int WIN_LSB  = 5;
  localparam int PORT_LSB = 2;
  localparam int PORT_W   = WIN_LSB - PORT_LSB;

  typedef enum logic [1:0] {
    PORT_LO   = 2'd0,
    PORT_HI   = 2'd1,
    PORT_DATA = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  function automatic port_e port_of(input logic [PORT_W-1:0] sel);
    case (sel)
      3'd0:    return PORT_LO;
      3'd1:    return PORT_HI;
      3'd2:    return PORT_DATA;
      default: return PORT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pmio_win_decode.sv
module pmio_win_decode
  import pmio_ram_reader_pkg::*;
#(
  parameter int              IO_ADDR_W = 10,
  parameter logic [IO_ADDR_W-1:0] WIN_BASE = 10'h300
) (
  input  logic [IO_ADDR_W-1:0] addr_i,
  input  logic                 aen_i,
  input  logic                 rd_ni,
  input  logic                 wr_ni,
  output logic                 card_sel_o,
  output logic                 rd_hit_o,
  output logic                 wr_hit_o,
  output port_e                port_o
);
  localparam int TAG_W = IO_ADDR_W - WIN_LSB;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[IO_ADDR_W-1:WIN_LSB];

  logic win_hit;
  logic unused_low_bits;

  assign unused_low_bits = ^{addr_i[PORT_LSB-1:0], WIN_BASE[WIN_LSB-1:0]};
  // processor cycles only; DMA cycles leave the card deselected
  assign win_hit    = (addr_i[IO_ADDR_W-1:WIN_LSB] == WIN_TAG) && !aen_i;
  assign rd_hit_o   = win_hit && !rd_ni;
  assign wr_hit_o   = win_hit && !wr_ni;
  assign card_sel_o = rd_hit_o || wr_hit_o;
  assign port_o     = port_of(addr_i[WIN_LSB-1:PORT_LSB]);
endmodule

// File: rtl/pmio_addr_regs.sv
module pmio_addr_regs
  import pmio_ram_reader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  port_e             port_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o
);
  logic              wr_act_q, wr_prev_q;
  port_e             cap_port_q;
  logic [DATA_W-1:0] cap_data_q;
  logic              commit;

  // capture while strobe active, commit on sampled release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q   <= 1'b0;
      wr_prev_q  <= 1'b0;
      cap_port_q <= PORT_NONE;
      cap_data_q <= '0;
    end else begin
      wr_act_q  <= wr_hit_i;
      wr_prev_q <= wr_act_q;
      if (wr_hit_i) begin
        cap_port_q <= port_i;
        cap_data_q <= data_i;
      end
    end
  end

  assign commit = wr_prev_q && !wr_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (commit) begin
      case (cap_port_q)
        PORT_LO: lo_o <= cap_data_q;
        PORT_HI: hi_o <= cap_data_q[HI_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pmio_read_mux.sv
module pmio_read_mux
  import pmio_ram_reader_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5
) (
  input  logic              rd_hit_i,
  input  port_e             port_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [DATA_W-1:0] ram_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ram_oe_o
);
  always_comb begin
    data_o   = '1;
    ram_oe_o = 1'b0;
    if (rd_hit_i) begin
      case (port_i)
        PORT_LO:   data_o = lo_i;
        PORT_HI:   data_o = {{(DATA_W-HI_W){1'b0}}, hi_i};
        PORT_DATA: begin
          data_o   = ram_data_i;
          ram_oe_o = 1'b1;
        end
        default:   data_o = '1;
      endcase
    end
  end
endmodule

// File: rtl/pmio_ram_reader.sv
module pmio_ram_reader
  import pmio_ram_reader_pkg::*;
#(
  parameter int IO_ADDR_W  = 10,
  parameter int DATA_W     = 8,
  parameter int HI_W       = 5,
  parameter int RAM_ADDR_W = 11,
  parameter logic [IO_ADDR_W-1:0] WIN_BASE = 10'h300,
  localparam int FULL_W    = DATA_W + HI_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IO_ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0]    io_data_i,
  input  logic                 io_rd_ni,
  input  logic                 io_wr_ni,
  input  logic                 aen_i,
  output logic [DATA_W-1:0]    io_data_o,
  output logic                 io_data_oe_o,
  output logic                 xcvr_dir_o,
  output logic                 card_sel_o,
  output logic [FULL_W-1:0]    ram_addr_o,
  output logic                 ram_cs_no,
  output logic                 ram_oe_no,
  input  logic [DATA_W-1:0]    ram_data_i
);
  logic              rd_hit, wr_hit, ram_oe;
  port_e             port;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [FULL_W-1:0] full_addr;

  pmio_win_decode #(.IO_ADDR_W(IO_ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr_i     (io_addr_i),
    .aen_i      (aen_i),
    .rd_ni      (io_rd_ni),
    .wr_ni      (io_wr_ni),
    .card_sel_o (card_sel_o),
    .rd_hit_o   (rd_hit),
    .wr_hit_o   (wr_hit),
    .port_o     (port)
  );

  pmio_addr_regs #(.DATA_W(DATA_W), .HI_W(HI_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .port_i   (port),
    .data_i   (io_data_i),
    .lo_o     (lo_q),
    .hi_o     (hi_q)
  );

  pmio_read_mux #(.DATA_W(DATA_W), .HI_W(HI_W)) u_rmux (
    .rd_hit_i   (rd_hit),
    .port_i     (port),
    .lo_i       (lo_q),
    .hi_i       (hi_q),
    .ram_data_i (ram_data_i),
    .data_o     (io_data_o),
    .ram_oe_o   (ram_oe)
  );

  assign full_addr = {hi_q, lo_q};

  // bits above the configured RAM size are tied low
  for (genvar i = 0; i < FULL_W; i++) begin : g_mask
    if (i < RAM_ADDR_W) begin : g_pass
      assign ram_addr_o[i] = full_addr[i];
    end else begin : g_zero
      assign ram_addr_o[i] = 1'b0;
    end
  end

  assign io_data_oe_o = rd_hit;
  assign xcvr_dir_o   = !io_rd_ni;
  assign ram_cs_no    = !card_sel_o;
  assign ram_oe_no    = !ram_oe;
endmodule

// File: rtl/pmio_ram_reader_chk.sv
module pmio_ram_reader_chk #(
  parameter int IO_ADDR_W  = 10,
  parameter int DATA_W     = 8,
  parameter int FULL_W     = 13,
  parameter int RAM_ADDR_W = 11,
  parameter logic [IO_ADDR_W-1:0] WIN_BASE = 10'h300
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [IO_ADDR_W-1:0] io_addr_i,
  input logic                 io_rd_ni,
  input logic                 io_wr_ni,
  input logic                 aen_i,
  input logic [DATA_W-1:0]    io_data_o,
  input logic                 io_data_oe_o,
  input logic                 xcvr_dir_o,
  input logic                 ram_cs_no,
  input logic                 ram_oe_no,
  input logic [DATA_W-1:0]    ram_data_i,
  input logic [FULL_W-1:0]    ram_addr_o
);
  logic past_ok;
  logic in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign in_win = io_addr_i[IO_ADDR_W-1:5] == WIN_BASE[IO_ADDR_W-1:5];

  p_out_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> ram_cs_no);

  p_aen_block_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> ram_cs_no);

  p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_addr_o >> RAM_ADDR_W) == '0);

  p_ram_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> (!ram_cs_no && !io_rd_ni && io_data_o == ram_data_i));

  p_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && !aen_i && !io_rd_ni && io_addr_i[4:2] > 3'd2) |-> io_data_o == '1);

  p_dir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_data_oe_o |-> (xcvr_dir_o && !ram_cs_no));

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(!io_wr_ni)) |-> $stable(ram_addr_o));
endmodule

bind pmio_ram_reader pmio_ram_reader_chk #(
  .IO_ADDR_W (IO_ADDR_W),
  .DATA_W    (DATA_W),
  .FULL_W    (FULL_W),
  .RAM_ADDR_W(RAM_ADDR_W),
  .WIN_BASE  (WIN_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_addr_i   (io_addr_i),
  .io_rd_ni    (io_rd_ni),
  .io_wr_ni    (io_wr_ni),
  .aen_i       (aen_i),
  .io_data_o   (io_data_o),
  .io_data_oe_o(io_data_oe_o),
  .xcvr_dir_o  (xcvr_dir_o),
  .ram_cs_no   (ram_cs_no),
  .ram_oe_no   (ram_oe_no),
  .ram_data_i  (ram_data_i),
  .ram_addr_o  (ram_addr_o)
);

// File: tb/pmio_ram_reader_test.sv
module pmio_ram_reader_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  io_addr = 10'h000;
  logic [7:0]  io_wdata = 8'h00;
  logic        rd_n = 1'b1, wr_n = 1'b1, aen = 1'b0;
  logic [7:0]  io_rdata, ram_data;
  logic        data_oe, dir, card_sel, ram_cs_n, ram_oe_n;
  logic [12:0] ram_addr;

  int checks = 0, fails = 0;
  bit settling = 1'b0, done = 1'b0;
  int m_lo = 0, m_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural RAM content
  assign ram_data = ram_addr[7:0] ^ {3'b000, ram_addr[12:8]} ^ 8'h5A;

  pmio_ram_reader uut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_data_i(io_wdata),
    .io_rd_ni(rd_n), .io_wr_ni(wr_n), .aen_i(aen), .io_data_o(io_rdata),
    .io_data_oe_o(data_oe), .xcvr_dir_o(dir), .card_sel_o(card_sel),
    .ram_addr_o(ram_addr), .ram_cs_no(ram_cs_n), .ram_oe_no(ram_oe_n),
    .ram_data_i(ram_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_addr();
    return ((m_hi << 8) | m_lo) & 13'h07FF;
  endfunction

  function automatic int mem_of(input int a);
    return (a & 8'hFF) ^ ((a >> 8) & 8'h1F) ^ 8'h5A;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit sel, rd;
      int sub, exp_d;
      sel = (io_addr[9:5] == 5'b11000) && !aen && (!rd_n || !wr_n);
      rd  = sel && !rd_n;
      sub = int'(io_addr[4:2]);
      check("R1 card_sel", int'(card_sel), int'(sel));
      check("R1 ram_cs_n", int'(ram_cs_n), int'(!sel));
      check("R10 dir", int'(dir), int'(!rd_n));
      check("R10 oe", int'(data_oe), int'(rd));
      check("R7 ram_oe_n", int'(ram_oe_n), int'(!(rd && sub == 2)));
      if (rd) begin
        case (sub)
          0: exp_d = m_lo;
          1: exp_d = m_hi;
          2: exp_d = mem_of(exp_addr());
          default: exp_d = 8'hFF;
        endcase
        check("R7 rdata", int'(io_rdata), exp_d);
      end
      if (!settling) check("R12 ram_addr", int'(ram_addr), exp_addr());
    end
  end

  task automatic io_write(input logic [9:0] a, input logic [7:0] d,
                          input logic dma, input int hold);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; aen = dma; wr_n = 1'b0;
    repeat (hold) @(posedge clk);
    #1 wr_n = 1'b1; settling = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    if (a[9:5] == 5'b11000 && !dma) begin
      if (a[4:2] == 3'd0) m_lo = int'(d);
      if (a[4:2] == 3'd1) m_hi = int'(d[4:0]);
    end
    settling = 1'b0; aen = 1'b0; io_addr = 10'h000;
  endtask

  task automatic io_read(input logic [9:0] a, input logic dma,
                         input string tag, input int exp);
    @(posedge clk); #1;
    io_addr = a; aen = dma; rd_n = 1'b0;
    @(negedge clk); #1;
    check(tag, int'(io_rdata), exp);
    @(posedge clk); #1;
    rd_n = 1'b1; aen = 1'b0; io_addr = 10'h000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset addr", int'(ram_addr), 0);
    check("R11 reset sel", int'(card_sel), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    io_read(10'h300, 1'b0, "R11 lo after reset", 0);
    io_write(10'h300, 8'hA5, 1'b0, 2);
    check("R4 lo commit", int'(ram_addr), 13'h0A5);
    io_read(10'h302, 1'b0, "R8 lo readback", 8'hA5);
    io_write(10'h304, 8'h03, 1'b0, 2);
    check("R5 hi commit", int'(ram_addr), 13'h3A5);
    io_read(10'h308, 1'b0, "R7 data read", mem_of(13'h3A5));
    io_write(10'h304, 8'hFF, 1'b0, 2);
    check("R6 masked addr", int'(ram_addr), 13'h7A5);
    io_read(10'h305, 1'b0, "R8 hi readback", 8'h1F);
    io_read(10'h309, 1'b0, "R6 data at masked addr", mem_of(13'h7A5));
    io_write(10'h301, 8'h3C, 1'b0, 5);
    check("R12 commit after long hold", int'(ram_addr), 13'h73C);
    io_write(10'h300, 8'h11, 1'b1, 2);
    check("R2 dma write ignored", int'(ram_addr), 13'h73C);
    io_read(10'h300, 1'b1, "R2 dma read deselected", 8'hFF);
    io_write(10'h30C, 8'h22, 1'b0, 2);
    io_write(10'h308, 8'h33, 1'b0, 2);
    io_read(10'h300, 1'b0, "R9 lo untouched", 8'h3C);
    io_read(10'h304, 1'b0, "R9 hi untouched", 8'h1F);
    io_read(10'h30C, 1'b0, "R9 reserved read", 8'hFF);
    io_read(10'h31C, 1'b0, "R9 top reserved read", 8'hFF);
    io_write(10'h320, 8'h44, 1'b0, 2);
    io_write(10'h2E0, 8'h55, 1'b0, 2);
    check("R1 outside window write", int'(ram_addr), 13'h73C);
    io_write(10'h307, 8'h02, 1'b0, 2);
    check("R3 hi alias", int'(ram_addr), 13'h23C);
    io_write(10'h303, 8'hC3, 1'b0, 2);
    check("R3 lo alias", int'(ram_addr), 13'h2C3);
    io_read(10'h30B, 1'b0, "R3 data alias", mem_of(13'h2C3));

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule